// File: doc/BRIEF.md
# Shared-Timebase Edge-Placed PWM Bank

This block drives up to sixteen pulse-width outputs from one common timebase. A clock divider counts input clocks up to a programmed divide value and then emits a step tick. A step counter advances on every tick and wraps to zero after a programmed last step. The period, measured in input clocks, is therefore (divide + 1) x (last step + 1), and it is the same for every channel.

Each channel is not given a duty cycle. It is given two absolute step positions instead: one where the output rises and one where it falls. An edge position beyond the last step never matches, which gives a constant level. Equal positions make the output invert at that step, so it runs at half the frequency with a 50% duty cycle.

A channel can be put in synchronised mode. In that mode, a write to its edge registers lands in a hidden holding copy, which is moved into the working edges only when the period wraps. Channels outside that mode take new edges at once. All settings are written and read through a plain byte-wide register port whose read data is combinational.

Top module: `pwm_bank`

## Requirements
- R1: After reset the divider counts 0..divide (address 0) and ticks on reaching it. The step counter advances on each tick and wraps from the last step (address 1) to 0. Each output period is (divide+1)*(last+1) input clocks.
- R2: Writes to address 0 (divide) and address 1 (last step) are read back unchanged on `reg_rdata` in the cycle after the write.
- R3: Channel c has its rise position at address 16+2c and its fall position at address 17+2c. On the first clock of a step equal to only the rise position, the output goes high on the next edge. On the first clock of a step equal to only the fall position, the output goes low on the next edge. The output does not change on any other clock.
- R4: When rise and fall positions are equal, the output inverts at that step. The result is a 50% waveform with twice the programmed period.
- R5: A rise position greater than the last step leaves an enabled output low. A fall position greater than the last step, together with rise at 0, leaves the output high once it has risen.
- R6: Address 2 bit b enables channel b (0..7), and address 3 bit b enables channel 8+b. A disabled output is low from the next edge. A write to one enable byte leaves the other byte's channels unchanged.
- R7: Address 4 bit b (channels 0..7) and address 5 bit b (channels 8..15) select synchronised mode. A write to a synchronised channel's edges has no effect on its output until the step counter wraps. The held value then becomes active for the next period.
- R8: Reading an edge address returns the active value. A pending held value is not visible until the wrap.
- R9: For a channel not in synchronised mode, an edge write becomes active in the next cycle, even in mid-period, and is read back at once.
- R10: Reset sets every register, counter and output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pwm_out | output | NUM_CH | Channel outputs, registered |

## Verification
Register writes land on the clock edge where `reg_we` is high. Read data is valid in the same cycle that the address is presented. An output level is due one clock after the first clock of the step whose position matches. Held edges become active on the edge that wraps the step counter, so their effect shows from the first step of the next period. A behavioural model in the bench advances on the same clock edge, and both outputs and model are compared on the falling edge, away from every register update. Periods and high times are also measured at the pins and compared against figures computed by hand from R1, R3 and R4.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int DW          = 8;
  localparam int MAX_CH      = 16;
  localparam int A_DIVIDE    = 0;
  localparam int A_LAST      = 1;
  localparam int A_EN_LO     = 2;
  localparam int A_EN_HI     = 3;
  localparam int A_SYNC_LO   = 4;
  localparam int A_SYNC_HI   = 5;
  localparam int A_EDGE_BASE = 16;
endpackage

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
  import pwm_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] divide,
  input  logic [DW-1:0] last_step,
  output logic [DW-1:0] step_cnt,
  output logic          step_new,
  output logic          boundary
);
  logic [DW-1:0] div_q;
  logic          tick;
  logic          wrap;

  // >= so that a shrunken setting ends the current count at once
  assign tick     = (div_q >= divide);
  assign wrap     = (step_cnt >= last_step);
  assign boundary = tick & wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q    <= '0;
      step_cnt <= '0;
      step_new <= 1'b1;
    end else begin
      div_q    <= tick ? '0 : div_q + 1'b1;
      step_new <= tick;
      if (tick) step_cnt <= wrap ? '0 : step_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int ADDR_W     = 6,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DW-1:0]               wdata,
  input  logic                        boundary,
  output logic [DW-1:0]               divide,
  output logic [DW-1:0]               last_step,
  output logic [NUM_CH-1:0]           en,
  output logic [NUM_CH-1:0]           sync,
  output logic [NUM_CH-1:0][DW-1:0]   rise_act,
  output logic [NUM_CH-1:0][DW-1:0]   fall_act,
  output logic [DW-1:0]               rdata
);
  localparam int PAD_CH = MAX_CH;

  logic [PAD_CH-1:0] en_pad;
  logic [PAD_CH-1:0] sync_pad;

  always_ff @(posedge clk) begin
    if (rst) begin
      divide    <= '0;
      last_step <= '0;
      en        <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(A_DIVIDE)) divide    <= wdata;
      if (addr == ADDR_W'(A_LAST))   last_step <= wdata;
      for (int c = 0; c < NUM_CH; c++)
        if (addr == ADDR_W'(A_EN_LO + c / 8)) en[c] <= wdata[c % 8];
    end
  end

  generate
    if (HAS_SHADOW) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sync <= '0;
        else if (we)
          for (int c = 0; c < NUM_CH; c++)
            if (addr == ADDR_W'(A_SYNC_LO + c / 8)) sync[c] <= wdata[c % 8];
      end
    end else begin : g_nosync
      assign sync = '0;
    end
  endgenerate

  for (genvar c = 0; c < NUM_CH; c++) begin : g_edge
    localparam logic [ADDR_W-1:0] A_R = ADDR_W'(A_EDGE_BASE + 2 * c);
    localparam logic [ADDR_W-1:0] A_F = ADDR_W'(A_EDGE_BASE + 2 * c + 1);
    logic wr_r, wr_f;
    assign wr_r = we && (addr == A_R);
    assign wr_f = we && (addr == A_F);

    if (HAS_SHADOW) begin : g_shd
      logic [DW-1:0] rise_hold, fall_hold;
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_hold   <= '0;
          fall_hold   <= '0;
          rise_act[c] <= '0;
          fall_act[c] <= '0;
        end else begin
          if (wr_r) rise_hold <= wdata;
          if (wr_f) fall_hold <= wdata;
          if (wr_r && !sync[c])         rise_act[c] <= wdata;
          else if (boundary && sync[c]) rise_act[c] <= rise_hold;
          if (wr_f && !sync[c])         fall_act[c] <= wdata;
          else if (boundary && sync[c]) fall_act[c] <= fall_hold;
        end
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_act[c] <= '0;
          fall_act[c] <= '0;
        end else begin
          if (wr_r) rise_act[c] <= wdata;
          if (wr_f) fall_act[c] <= wdata;
        end
      end
    end
  end

  assign en_pad   = PAD_CH'(en);
  assign sync_pad = PAD_CH'(sync);

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_DIVIDE))  rdata = divide;
    if (addr == ADDR_W'(A_LAST))    rdata = last_step;
    if (addr == ADDR_W'(A_EN_LO))   rdata = en_pad[7:0];
    if (addr == ADDR_W'(A_EN_HI))   rdata = en_pad[15:8];
    if (addr == ADDR_W'(A_SYNC_LO)) rdata = sync_pad[7:0];
    if (addr == ADDR_W'(A_SYNC_HI)) rdata = sync_pad[15:8];
    for (int c = 0; c < NUM_CH; c++) begin
      if (addr == ADDR_W'(A_EDGE_BASE + 2 * c))     rdata = rise_act[c];
      if (addr == ADDR_W'(A_EDGE_BASE + 2 * c + 1)) rdata = fall_act[c];
    end
  end
endmodule

// File: rtl/pwm_bank_channel.sv
module pwm_bank_channel
  import pwm_bank_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          step_new,
  input  logic [DW-1:0] step_cnt,
  input  logic [DW-1:0] rise_pos,
  input  logic [DW-1:0] fall_pos,
  input  logic          enable,
  output logic          level
);
  logic hit_r, hit_f, nxt;

  assign hit_r = (step_cnt == rise_pos);
  assign hit_f = (step_cnt == fall_pos);

  always_comb begin
    nxt = level;
    if (step_new) begin
      if (hit_r && hit_f) nxt = ~level;
      else if (hit_r)     nxt = 1'b1;
      else if (hit_f)     nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= enable ? nxt : 1'b0;
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int ADDR_W     = 6,
  parameter bit HAS_SHADOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [DW-1:0]             divide, last_step, step_cnt;
  logic                      step_new, boundary;
  logic [NUM_CH-1:0]         en, sync;
  logic [NUM_CH-1:0][DW-1:0] rise_act, fall_act;

  pwm_bank_timebase u_tb (
    .clk(clk), .rst(rst), .divide(divide), .last_step(last_step),
    .step_cnt(step_cnt), .step_new(step_new), .boundary(boundary)
  );

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .HAS_SHADOW(HAS_SHADOW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .boundary(boundary), .divide(divide), .last_step(last_step), .en(en),
    .sync(sync), .rise_act(rise_act), .fall_act(fall_act), .rdata(reg_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_channel u_ch (
      .clk(clk), .rst(rst), .step_new(step_new), .step_cnt(step_cnt),
      .rise_pos(rise_act[c]), .fall_pos(fall_act[c]), .enable(en[c]),
      .level(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_bank_sva.sv
module pwm_bank_sva
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      reg_we,
  input logic                      boundary,
  input logic                      step_new,
  input logic [DW-1:0]             step_cnt,
  input logic [NUM_CH-1:0]         en,
  input logic [NUM_CH-1:0]         sync,
  input logic [NUM_CH-1:0][DW-1:0] rise_act,
  input logic [NUM_CH-1:0][DW-1:0] fall_act,
  input logic [NUM_CH-1:0]         pwm_out
);
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (step_cnt == '0)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step_new |=> (pwm_out == ($past(pwm_out) & $past(en)))); // R3

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pwm_out & ~$past(en)) == '0)); // R6

  AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!reg_we && !boundary) |=> ($stable(rise_act) && $stable(fall_act))); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_SYNC_NO_MIDLOAD: assert property (@(posedge clk) disable iff (rst)
      (sync[c] && !boundary) |=> ($stable(rise_act[c]) && $stable(fall_act[c]))); // R7
  end
endmodule

bind pwm_bank pwm_bank_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk(clk), .rst(rst), .reg_we(reg_we), .boundary(boundary),
  .step_new(step_new), .step_cnt(step_cnt), .en(en), .sync(sync),
  .rise_act(rise_act), .fall_act(fall_act), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int AW  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [NCH-1:0] pwm_out;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R10";
  bit    finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW), .HAS_SHADOW(1'b1)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  // behavioural reference model
  int       m_div, m_last, m_dc, m_step;
  bit       m_new;
  bit [15:0] m_en, m_sync, m_out;
  int       m_ra[16], m_fa[16], m_rh[16], m_fh[16];
  bit       t_tick, t_wrap;
  bit [15:0] t_sync;

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_last = 0; m_dc = 0; m_step = 0; m_new = 1;
      m_en = 0; m_sync = 0; m_out = 0;
      for (int c = 0; c < 16; c++) begin
        m_ra[c] = 0; m_fa[c] = 0; m_rh[c] = 0; m_fh[c] = 0;
      end
    end else begin
      t_tick = (m_dc >= m_div);
      t_wrap = (m_step >= m_last);
      t_sync = m_sync;
      for (int c = 0; c < 16; c++) begin
        if (!m_en[c]) m_out[c] = 0;
        else if (m_new) begin
          if (m_step == m_ra[c] && m_step == m_fa[c]) m_out[c] = ~m_out[c];
          else if (m_step == m_ra[c]) m_out[c] = 1;
          else if (m_step == m_fa[c]) m_out[c] = 0;
        end
      end
      if (t_tick && t_wrap)
        for (int c = 0; c < 16; c++)
          if (t_sync[c]) begin m_ra[c] = m_rh[c]; m_fa[c] = m_fh[c]; end
      if (reg_we) begin
        case (int'(reg_addr))
          0: m_div = reg_wdata;
          1: m_last = reg_wdata;
          2: m_en[7:0] = reg_wdata;
          3: m_en[15:8] = reg_wdata;
          4: m_sync[7:0] = reg_wdata;
          5: m_sync[15:8] = reg_wdata;
          default: ;
        endcase
        for (int c = 0; c < 16; c++) begin
          if (int'(reg_addr) == 16 + 2 * c) begin
            m_rh[c] = reg_wdata; if (!t_sync[c]) m_ra[c] = reg_wdata;
          end
          if (int'(reg_addr) == 17 + 2 * c) begin
            m_fh[c] = reg_wdata; if (!t_sync[c]) m_fa[c] = reg_wdata;
          end
        end
      end
      m_dc = t_tick ? 0 : m_dc + 1;
      if (t_tick) m_step = t_wrap ? 0 : m_step + 1;
      m_new = t_tick;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !finished) chk({cur_req, " pwm_out vs model"}, int'(pwm_out), int'(m_out));
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = 8'(d); reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk);
    reg_addr = AW'(a);
    #1;
    chk({req, " readback"}, int'(reg_rdata), exp);
  endtask

  task automatic meas(int ch, output int per, output int hi);
    bit prev;
    int guard;
    per = 0; hi = 0; guard = 0;
    @(negedge clk);
    prev = pwm_out[ch];
    while (!(pwm_out[ch] && !prev) && guard < 500) begin
      prev = pwm_out[ch]; @(negedge clk); guard++;
    end
    per = 1; hi = 1; prev = 1'b1;
    forever begin
      @(negedge clk);
      if ((pwm_out[ch] && !prev) || per > 500) break;
      per++;
      if (pwm_out[ch]) hi++;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int per, hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: everything cleared after reset
    cur_req = "R10";
    for (int a = 0; a < 6; a++) rd(a, 0, "R10");
    rd(16, 0, "R10"); rd(47, 0, "R10");
    chk("R10 pwm_out", int'(pwm_out), 0);

    // R2: timebase settings read back
    cur_req = "R2";
    wr(0, 1); wr(1, 9);
    rd(0, 1, "R2"); rd(1, 9, "R2");

    // R1/R3: ch0 rises at 2, falls at 6
    cur_req = "R3";
    wr(16, 2); wr(17, 6); wr(2, 8'h01);
    meas(0, per, hi);
    chk("R1 period clocks", per, 20);
    chk("R3 high clocks", hi, 8);

    // R4: equal edges on ch1
    cur_req = "R4";
    wr(18, 3); wr(19, 3); wr(2, 8'h03);
    meas(1, per, hi);
    chk("R4 toggle period", per, 40);
    chk("R4 toggle high", hi, 20);

    // R5: out-of-range edges
    cur_req = "R5";
    wr(20, 10); wr(21, 0); wr(22, 0); wr(23, 10); wr(2, 8'h0F);
    repeat (25) @(negedge clk);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (i % 8 == 0) begin
        chk("R5 ch2 stays low", int'(pwm_out[2]), 0);
        chk("R5 ch3 stays high", int'(pwm_out[3]), 1);
      end
    end

    // R6: upper enable byte independent of lower
    cur_req = "R6";
    wr(34, 1); wr(35, 5); wr(3, 8'h02);
    repeat (25) @(negedge clk);
    wr(2, 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 ch0 low when disabled", int'(pwm_out[0]), 0);
    chk("R6 ch3 low when disabled", int'(pwm_out[3]), 0);
    rd(3, 8'h02, "R6");
    meas(9, per, hi);
    chk("R6 ch9 still running period", per, 20);
    chk("R6 ch9 high clocks", hi, 8);

    // R7/R8: synchronised ch0
    cur_req = "R7";
    wr(2, 8'h01); wr(4, 8'h01);
    rd(4, 8'h01, "R7");
    wr(16, 4);
    rd(16, 2, "R8 pending hidden");
    repeat (25) @(negedge clk);
    rd(16, 4, "R7 loaded at wrap");
    meas(0, per, hi);
    chk("R7 new high clocks", hi, 4);
    chk("R7 period unchanged", per, 20);

    // R9: immediate update on non-synchronised ch9
    cur_req = "R9";
    wr(35, 7);
    rd(35, 7, "R9");
    meas(9, per, hi);
    chk("R9 ch9 high clocks", hi, 12);
    repeat (30) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule